// File: doc/BRIEF.md
# VLAN ID Hash Filter

This block decides, frame by frame, whether a received frame may pass on the basis of its VLAN identifier. For each offered frame it looks at the tag-present flag, the 16-bit tag protocol identifier and the 16-bit tag control field. It hashes the 12-bit VLAN ID with a serial CRC-32 engine and looks up one bit of a 16-bit hash table. The frame passes if that bit is set, or if the VID equals a configured identifier.

Frames that carry no customer tag are not filtered, and neither are frames offered while promiscuous mode is on or the filter is switched off. A register port writes the hash table and the configured VID. The same CRC engine also serves a table-build helper: it hashes a given VID and ORs the matching bit into the table. A clear input empties the table.

Top module: `vlan_hash_filter`

## Requirements
- R1: Only bits 11:0 of the tag control field (the VID) affect the decision. Bits 15:12 never change it.
- R2: The table index is found as follows. Start a reflected CRC-32 (polynomial 0xEDB88320) at all ones. Feed it the 12 VID bits, bit 0 first. Each step computes f = crc[0] xor d, shifts the CRC right by one and XORs in the polynomial when f is 1. The index is then {~crc[0], ~crc[1], ~crc[2], ~crc[3]}, with ~crc[0] as its most significant bit.
- R3: A filtered frame passes exactly when `hash_table[index]` is 1 in the cycle its decision is made, or when R4 applies. Otherwise it is dropped (`dec_pass` = 0).
- R4: A frame whose VID equals the configured VID always passes. The configured VID resets to 1. It is written with `cfg_we`=1 and `cfg_sel`=1 from `cfg_wdata[11:0]`.
- R5: A frame is filtered only when `frm_tagged`=1 and `frm_tpid`=0x8100. Untagged frames and frames with any other type (such as 0x88A8) pass.
- R6: A frame offered while `promisc`=1 or `filt_en`=0 passes. Both inputs are sampled when the frame is accepted.
- R7: A frame is accepted on a clock edge where `frm_valid`=1 and `frm_ready`=1. Exactly 12 edges later, `dec_valid` is high for one cycle together with `dec_pass`. `frm_ready` is low from the acceptance edge until the decision edge.
- R8: `bld_start` is accepted when the engine is idle and `frm_valid`=0; a frame offered in the same cycle wins and the build request is dropped. Twelve edges after an accepted build, the table bit of `bld_vid` is ORed in. The table never loses bits except through R9.
- R9: The table is written with `cfg_we`=1 and `cfg_sel`=0 from `cfg_wdata[15:0]`. That write takes precedence over `bld_clear`, which zeroes the table. A build bit that completes on the same edge is ORed into whichever of these results applies.
- R10: After reset the table is 0, `frm_ready`=1 and `dec_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| filt_en | input | 1 | VLAN filtering enabled |
| promisc | input | 1 | Promiscuous mode, pass everything |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 writes the hash table, 1 writes the configured VID |
| cfg_wdata | input | 16 | Register write data |
| frm_valid | input | 1 | Frame header offered |
| frm_tagged | input | 1 | Frame carries a tag |
| frm_tpid | input | 16 | Tag protocol identifier |
| frm_tci | input | 16 | Tag control field |
| frm_ready | output | 1 | Engine idle, frame or build may be accepted |
| dec_valid | output | 1 | Decision strobe |
| dec_pass | output | 1 | 1 = pass, 0 = drop |
| bld_start | input | 1 | Table-build request |
| bld_vid | input | 12 | VID to add to the table |
| bld_clear | input | 1 | Zero the table |
| hash_table | output | 16 | Current hash table |

## Verification
Two pairs of events can fall on the same clock edge. In the first, a frame request and a build request are both offered to the idle engine. The bench drives both together and expects the frame to be taken and the table to stay unchanged. In the second, a build finishes on the edge where `bld_clear` or a table write arrives. The bench times the clear, and separately the write, onto the twelfth edge after the build and expects the surviving value ORed with the new bit. A behavioural model that computes the hash with integer arithmetic is compared against every output on every cycle.

// File: rtl/vlan_hash_filter.sv
module vlan_hash_filter #(
  parameter int VID_W = 12,
  parameter int TBL_W = 16,
  parameter int CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320,
  parameter logic [15:0] CTAG_TPID = 16'h8100,
  parameter logic [VID_W-1:0] VID_RST = 12'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             filt_en,
  input  logic             promisc,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [15:0]      cfg_wdata,
  input  logic             frm_valid,
  input  logic             frm_tagged,
  input  logic [15:0]      frm_tpid,
  input  logic [15:0]      frm_tci,
  output logic             frm_ready,
  output logic             dec_valid,
  output logic             dec_pass,
  input  logic             bld_start,
  input  logic [VID_W-1:0] bld_vid,
  input  logic             bld_clear,
  output logic [TBL_W-1:0] hash_table
);
  localparam int IDX_W = $clog2(TBL_W);
  localparam int CNT_W = $clog2(VID_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(VID_W - 1);

  logic busy_q, bld_op_q, bypass_q, match_q, dv_q, pass_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CRC_W-1:0] crc_q, crc_nx;
  logic [VID_W-1:0] sh_q, vid_q;
  logic [TBL_W-1:0] tbl_q, tbl_base, set_vec;
  logic [IDX_W-1:0] idx;
  logic fb, last, take_frm, take_bld, tagged_c, hit;

  assign fb       = crc_q[0] ^ sh_q[0];
  assign crc_nx   = (crc_q >> 1) ^ (fb ? POLY : '0);

  for (genvar g = 0; g < IDX_W; g++) begin : g_idx
    assign idx[IDX_W-1-g] = ~crc_nx[g];
  end

  assign last     = busy_q && (cnt_q == LAST_CNT);
  assign take_frm = !busy_q && frm_valid;
  assign take_bld = !busy_q && !frm_valid && bld_start;
  assign tagged_c = frm_tagged && (frm_tpid == CTAG_TPID);
  assign hit      = tbl_q[idx];
  assign set_vec  = (last && bld_op_q) ? (TBL_W'(1) << idx) : '0;

  always_comb begin
    if (cfg_we && !cfg_sel) tbl_base = cfg_wdata[TBL_W-1:0];
    else if (bld_clear)     tbl_base = '0;
    else                    tbl_base = tbl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      bld_op_q <= 1'b0;
      bypass_q <= 1'b0;
      match_q  <= 1'b0;
      dv_q     <= 1'b0;
      pass_q   <= 1'b0;
      cnt_q    <= '0;
      crc_q    <= '1;
      sh_q     <= '0;
    end else begin
      dv_q <= 1'b0;
      if (take_frm) begin
        busy_q   <= 1'b1;
        bld_op_q <= 1'b0;
        cnt_q    <= '0;
        crc_q    <= '1;
        sh_q     <= frm_tci[VID_W-1:0];
        bypass_q <= promisc || !filt_en || !tagged_c;
        match_q  <= (frm_tci[VID_W-1:0] == vid_q);
      end else if (take_bld) begin
        busy_q   <= 1'b1;
        bld_op_q <= 1'b1;
        cnt_q    <= '0;
        crc_q    <= '1;
        sh_q     <= bld_vid;
        bypass_q <= 1'b0;
        match_q  <= 1'b0;
      end else if (busy_q) begin
        crc_q <= crc_nx;
        sh_q  <= sh_q >> 1;
        if (last) begin
          busy_q <= 1'b0;
          if (!bld_op_q) begin
            dv_q   <= 1'b1;
            pass_q <= bypass_q || match_q || hit;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q <= '0;
      vid_q <= VID_RST;
    end else begin
      tbl_q <= tbl_base | set_vec;
      if (cfg_we && cfg_sel) vid_q <= cfg_wdata[VID_W-1:0];
    end
  end

  assign frm_ready  = !busy_q;
  assign dec_valid  = dv_q;
  assign dec_pass   = pass_q;
  assign hash_table = tbl_q;

endmodule

// File: rtl/vlan_hash_filter_chk.sv
module vlan_hash_filter_chk #(
  parameter int TBL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             filt_en,
  input logic             promisc,
  input logic             cfg_we,
  input logic             cfg_sel,
  input logic             frm_valid,
  input logic             frm_ready,
  input logic             dec_valid,
  input logic             dec_pass,
  input logic             bld_clear,
  input logic [TBL_W-1:0] hash_table
);
  logic byp_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_seen <= 1'b0;
    else if (frm_valid && frm_ready) byp_seen <= promisc || !filt_en;
  end

  AST_DEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R7

  AST_DEC_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(!frm_ready)); // R7

  AST_TBL_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bld_clear && !(cfg_we && !cfg_sel)) |=>
      ((hash_table & $past(hash_table)) == $past(hash_table))); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (bld_clear && !(cfg_we && !cfg_sel)) |=> ($countones(hash_table) <= 1)); // R9

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && byp_seen) |-> dec_pass); // R6

endmodule

bind vlan_hash_filter vlan_hash_filter_chk #(.TBL_W(TBL_W)) u_chk (.*);

// File: tb/vlan_hash_filter_bench.sv
module vlan_hash_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic filt_en = 1'b0, promisc = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0, frm_tpid = '0, frm_tci = '0;
  logic frm_valid = 1'b0, frm_tagged = 1'b0, bld_start = 1'b0, bld_clear = 1'b0;
  logic [11:0] bld_vid = '0;
  logic frm_ready, dec_valid, dec_pass;
  logic [15:0] hash_table;

  always #2 clk = ~clk;

  vlan_hash_filter u_vlan_hash_filter (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_idx(input int vid);
    logic [31:0] c = 32'hFFFF_FFFF;
    int r = 0;
    for (int i = 0; i < 12; i++) begin
      if ((c[0] ^ vid[i]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
      else c = c >> 1;
    end
    c = ~c;
    for (int k = 0; k < 4; k++) r = (r << 1) | int'(c[k]);
    return r;
  endfunction

  // behavioural reference model
  int m_cnt, m_vid;
  bit m_build, m_byp, m_match, m_dv, m_pass;
  logic [15:0] m_tbl;
  int m_cfgvid;

  always @(posedge clk) begin
    logic [15:0] setb, base;
    int old_cnt;
    if (!rst_n) begin
      m_cnt = 0; m_dv = 0; m_pass = 0; m_tbl = '0; m_cfgvid = 1;
    end else begin
      setb = '0;
      m_dv = 0;
      old_cnt = m_cnt;
      if (old_cnt == 1) begin
        if (m_build) setb = 16'(1) << ref_idx(m_vid);
        else begin
          m_dv = 1;
          m_pass = m_byp || m_match || m_tbl[ref_idx(m_vid)];
        end
        m_cnt = 0;
      end else if (old_cnt > 1) m_cnt = old_cnt - 1;
      else if (frm_valid) begin
        m_cnt = 12; m_build = 0; m_vid = int'(frm_tci) % 4096;
        m_byp = promisc || !filt_en || !(frm_tagged && frm_tpid == 16'h8100);
        m_match = (m_vid == m_cfgvid);
      end else if (bld_start) begin
        m_cnt = 12; m_build = 1; m_vid = int'(bld_vid);
      end
      if (cfg_we && !cfg_sel) base = cfg_wdata;
      else if (bld_clear) base = '0;
      else base = m_tbl;
      m_tbl = base | setb;
      if (cfg_we && cfg_sel) m_cfgvid = int'(cfg_wdata) % 4096;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(frm_ready == (m_cnt == 0), "R7 ready", frm_ready, m_cnt == 0);
    chk(dec_valid == m_dv, "R7 dec_valid", dec_valid, m_dv);
    if (m_dv) chk(dec_pass == m_pass, "R3 dec_pass", dec_pass, m_pass);
    chk(hash_table == m_tbl, "R8 table", hash_table, m_tbl);
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic frame(input logic [15:0] tpid, input logic [15:0] tci, input bit tg, output bit p);
    int guard = 0;
    while (!frm_ready) tick();
    frm_valid = 1; frm_tpid = tpid; frm_tci = tci; frm_tagged = tg;
    tick();
    frm_valid = 0;
    while (!dec_valid && guard < 40) begin tick(); guard++; end
    p = dec_pass;
    tick();
  endtask

  task automatic build(input int vid);
    while (!frm_ready) tick();
    bld_start = 1; bld_vid = 12'(vid);
    tick();
    bld_start = 0;
  endtask

  task automatic wr(input bit sel, input logic [15:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit p;
    int ia, ib;
    tick(); tick();
    rst_n = 1;
    tick();
    chk(hash_table == 0, "R10 table", hash_table, 0);
    chk(frm_ready == 1, "R10 ready", frm_ready, 1);
    chk(dec_valid == 0, "R10 dec_valid", dec_valid, 0);
    filt_en = 1;

    frame(16'h8100, 16'h0001, 1, p); chk(p == 1, "R4 vid1 default", p, 1);
    frame(16'h8100, 16'h0002, 1, p); chk(p == 0, "R3 empty drop", p, 0);
    frame(16'h8100, 16'hE002, 1, p); chk(p == 0, "R1 pcp ignored drop", p, 0);
    frame(16'h8100, 16'hF001, 1, p); chk(p == 1, "R1 pcp ignored pass", p, 1);
    frame(16'h88A8, 16'h0002, 1, p); chk(p == 1, "R5 s-tag passes", p, 1);
    frame(16'h8100, 16'h0002, 0, p); chk(p == 1, "R5 untagged passes", p, 1);
    promisc = 1;
    frame(16'h8100, 16'h0002, 1, p); chk(p == 1, "R6 promisc", p, 1);
    promisc = 0; filt_en = 0;
    frame(16'h8100, 16'h0002, 1, p); chk(p == 1, "R6 disabled", p, 1);
    filt_en = 1;
    frame(16'h8100, 16'h0002, 1, p); chk(p == 0, "R6 filtering restored", p, 0);

    build(2);
    repeat (13) tick();
    chk(hash_table == (16'(1) << ref_idx(2)), "R2 build index", hash_table, 16'(1) << ref_idx(2));
    frame(16'h8100, 16'h0002, 1, p); chk(p == 1, "R3 table hit", p, 1);

    wr(1, 16'h0005);
    frame(16'h8100, 16'h0005, 1, p); chk(p == 1, "R4 cfg vid match", p, 1);

    // frame and build offered together: frame wins, build dropped
    wr(0, 16'h0000);
    frm_valid = 1; frm_tpid = 16'h8100; frm_tci = 16'h0009; frm_tagged = 1;
    bld_start = 1; bld_vid = 12'd9;
    tick();
    frm_valid = 0; bld_start = 0;
    repeat (14) tick();
    chk(hash_table == 0, "R8 build dropped on collision", hash_table, 0);

    // clear on the completion edge of a build
    wr(0, 16'hFFFF);
    build(7);
    repeat (11) tick();
    bld_clear = 1; tick(); bld_clear = 0;
    chk(hash_table == (16'(1) << ref_idx(7)), "R9 clear then OR", hash_table, 16'(1) << ref_idx(7));

    // table write on the completion edge of a build
    ia = ref_idx(11);
    build(11);
    repeat (11) tick();
    bld_clear = 1; wr(0, 16'h0100); bld_clear = 0;
    chk(hash_table == (16'h0100 | (16'(1) << ia)), "R9 write beats clear", hash_table,
        16'h0100 | (16'(1) << ia));

    for (int n = 0; n < 300; n++) begin
      ib = $urandom_range(0, 7);
      if (ib == 0) wr(0, 16'($urandom));
      else if (ib == 1) build($urandom_range(0, 4095));
      else if (ib == 2) wr(1, 16'($urandom_range(0, 4095)));
      else frame((ib == 3) ? 16'h88A8 : 16'h8100, 16'($urandom), ib != 4, p);
      promisc = ($urandom_range(0, 9) == 0);
      filt_en = ($urandom_range(0, 9) != 0);
    end
    repeat (20) tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule